// File: doc/BRIEF.md
# Per-Channel Burst Access Timing Sequencer

This block sets the timing of burst reads on a memory port that is shared by several channels. A requester offers a channel number and a burst length with a valid/ready handshake. The sequencer then counts base clock cycles and raises a one-cycle beat strobe at the end of each beat. It raises a done pulse together with the last beat. Address multiplexing, latch control, refresh and the pins of the memory protocol are handled elsewhere.

Each channel has a static slow-device bit. When the bit for the selected channel is set, every beat of that burst is one base clock longer. The first beat takes 5 cycles instead of 4, and each later beat takes 3 instead of 2. This lets a slow read-only device sit on one or more channels while the other channels keep full speed. The channel number and its slow bit are captured when the request is accepted.

Back-pressure rules: `req_ready` is high only while the sequencer is idle. A request is taken in any cycle where `req_valid` and `req_ready` are both high. The requester must hold its request until that happens. No request is taken from the cycle after acceptance up to and including the cycle of the done pulse.

Top module: `bseq_top`

## Requirements
- R1: While reset is applied and after it is released, `req_ready` is high and `beat_valid`, `burst_done` and `req_err` are low.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after a valid acceptance through the cycle of its done pulse, so requests offered during a burst are not taken.
- R3: With the captured slow bit clear, the first `beat_valid` pulse comes in the 4th cycle after the acceptance cycle.
- R4: With the slow bit clear, each later beat pulse comes 2 cycles after the previous one.
- R5: With the slow bit set, the first beat comes in the 5th cycle after acceptance and each later beat 3 cycles after the previous one.
- R6: Only the slow bit of the selected channel affects timing. `slow_mode[i]` belongs to channel i, and the bits of other channels have no effect.
- R7: The slow bit is sampled in the acceptance cycle. Changing `slow_mode` during a burst does not change that burst's timing.
- R8: `req_len` holds the beat count minus one (0 means 1 beat, 7 means 8 beats). Exactly that many beat pulses are produced, each lasting one cycle.
- R9: `burst_done` is high for one cycle, together with the last beat pulse. `req_ready` is high again in the next cycle.
- R10: A request to a channel above 5 is accepted and answered with a one-cycle `req_err` pulse in the next cycle. It produces no beats and `req_ready` stays high.
- R11: Several channels may have their slow bits set at once, and each of them then runs stretched timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_chan | input | 3 | Channel number of the request |
| req_len | input | 3 | Beats in the burst minus one |
| slow_mode | input | 6 | Slow-device bit per channel |
| beat_valid | output | 1 | One-cycle strobe at the end of each beat |
| burst_done | output | 1 | One-cycle pulse with the last beat |
| req_err | output | 1 | One-cycle pulse after a request to a channel above 5 |

## Verification
The bench goes after the edges of the beat count. A single-beat burst exposes a design that waits for a second beat or drops the done pulse. An eight-beat burst catches an off-by-one in the length that loses or adds a beat. A stretch applied to only the first beat, or only to later beats, shows up as beats that drift by one cycle. The bench changes the slow bits in the middle of a burst and sets the bits of non-selected channels, which catches designs that re-read the mode live or decode the wrong channel. It also holds the request valid across back-to-back bursts and sends channel numbers 6 and 7. A design that accepts early would overlap two bursts, and one that mishandles bad channels would start a burst on them or never pulse the error.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  localparam int DEF_NUM_CH     = 6;
  localparam int DEF_CH_W       = 3;
  localparam int DEF_LEN_W      = 3;
  localparam int DEF_BASE_FIRST = 4;
  localparam int DEF_BASE_NEXT  = 2;
  localparam int DEF_STRETCH    = 1;
endpackage

// File: rtl/bseq_lat_sel.sv
// Picks first-beat and later-beat reload values for the requested channel.
module bseq_lat_sel #(
  parameter int NUM_CH     = 6,
  parameter int CH_W       = 3,
  parameter int CNT_W      = 3,
  parameter int BASE_FIRST = 4,
  parameter int BASE_NEXT  = 2,
  parameter int STRETCH    = 1
) (
  input  logic [CH_W-1:0]   chan,
  input  logic [NUM_CH-1:0] slow_mode,
  output logic              chan_ok,
  output logic [CNT_W-1:0]  first_ld,
  output logic [CNT_W-1:0]  next_ld
);
  localparam logic [CH_W:0]    CH_LIM    = (CH_W+1)'(NUM_CH);
  localparam logic [CNT_W-1:0] FIRST_NRM = CNT_W'(BASE_FIRST - 1);
  localparam logic [CNT_W-1:0] FIRST_SLW = CNT_W'(BASE_FIRST + STRETCH - 1);
  localparam logic [CNT_W-1:0] NEXT_NRM  = CNT_W'(BASE_NEXT - 1);
  localparam logic [CNT_W-1:0] NEXT_SLW  = CNT_W'(BASE_NEXT + STRETCH - 1);

  logic [NUM_CH-1:0] hit;
  logic              slow;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign hit[g] = (chan == CH_W'(g)) && slow_mode[g];
  end

  assign slow     = |hit;
  assign chan_ok  = {1'b0, chan} < CH_LIM;
  assign first_ld = slow ? FIRST_SLW : FIRST_NRM;
  assign next_ld  = slow ? NEXT_SLW  : NEXT_NRM;
endmodule

// File: rtl/bseq_down_cnt.sv
// Loadable down counter that stops at zero.
module bseq_down_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (en && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/bseq_ctrl.sv
// Burst state machine: accepts requests, counts beats, flags bad channels.
module bseq_ctrl #(
  parameter int LEN_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             chan_ok,
  input  logic [CNT_W-1:0] first_ld,
  input  logic [CNT_W-1:0] next_ld,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_en,
  output logic             req_ready,
  output logic             beat_valid,
  output logic             burst_done,
  output logic             req_err
);
  import bseq_pkg::*;

  seq_state_t       state;
  logic [LEN_W-1:0] beats_left;
  logic [CNT_W-1:0] next_q;
  logic             err_q;
  logic             accept;
  logic             start;
  logic             reload;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign start      = accept && chan_ok;
  assign beat_valid = (state == ST_RUN) && cnt_zero;
  assign burst_done = beat_valid && (beats_left == '0);
  assign reload     = beat_valid && (beats_left != '0);
  assign req_err    = err_q;

  assign cnt_load = start || reload;
  assign cnt_val  = start ? first_ld : next_q;
  assign cnt_en   = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      beats_left <= '0;
      next_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= accept && !chan_ok;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_RUN;
            beats_left <= req_len;
            next_q     <= next_ld;
          end
        end
        ST_RUN: begin
          if (burst_done)  state      <= ST_IDLE;
          else if (reload) beats_left <= beats_left - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bseq_top.sv
// Per-channel burst timing sequencer.
module bseq_top #(
  parameter int NUM_CH     = bseq_pkg::DEF_NUM_CH,
  parameter int CH_W       = bseq_pkg::DEF_CH_W,
  parameter int LEN_W      = bseq_pkg::DEF_LEN_W,
  parameter int BASE_FIRST = bseq_pkg::DEF_BASE_FIRST,
  parameter int BASE_NEXT  = bseq_pkg::DEF_BASE_NEXT,
  parameter int STRETCH    = bseq_pkg::DEF_STRETCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [NUM_CH-1:0] slow_mode,
  output logic              beat_valid,
  output logic              burst_done,
  output logic              req_err
);
  localparam int CNT_W = $clog2(BASE_FIRST + STRETCH);

  logic             chan_ok;
  logic [CNT_W-1:0] first_ld;
  logic [CNT_W-1:0] next_ld;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_en;
  logic             cnt_zero;

  bseq_lat_sel #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W),
    .BASE_FIRST(BASE_FIRST), .BASE_NEXT(BASE_NEXT), .STRETCH(STRETCH)
  ) u_lat (
    .chan(req_chan), .slow_mode(slow_mode), .chan_ok(chan_ok),
    .first_ld(first_ld), .next_ld(next_ld)
  );

  bseq_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .en(cnt_en), .zero(cnt_zero)
  );

  bseq_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .chan_ok(chan_ok), .first_ld(first_ld), .next_ld(next_ld),
    .cnt_zero(cnt_zero), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .cnt_en(cnt_en), .req_ready(req_ready), .beat_valid(beat_valid),
    .burst_done(burst_done), .req_err(req_err)
  );
endmodule

// File: rtl/bseq_chk.sv
// Protocol checks on the sequencer ports.
module bseq_chk #(
  parameter int NUM_CH = 6,
  parameter int CH_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [CH_W-1:0] req_chan,
  input logic            beat_valid,
  input logic            burst_done,
  input logic            req_err
);
  logic bad_take;
  assign bad_take = req_valid && req_ready && ({1'b0, req_chan} >= (CH_W+1)'(NUM_CH));

  AST_BEAT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready); // R2
  AST_NO_EARLY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !beat_valid); // R3
  AST_BEAT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !burst_done) |=> !beat_valid); // R4
  AST_DONE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> beat_valid); // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> (req_ready && !burst_done)); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(bad_take)); // R10
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && !beat_valid)); // R10
endmodule

bind bseq_top bseq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_chan(req_chan), .beat_valid(beat_valid), .burst_done(burst_done),
  .req_err(req_err)
);

// File: tb/bseq_top_tb.sv
module bseq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [2:0] req_chan;
  logic [2:0] req_len;
  logic [5:0] slow_mode;
  logic       beat_valid;
  logic       burst_done;
  logic       req_err;

  always #4 clk = ~clk;

  bseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_len(req_len), .slow_mode(slow_mode),
    .beat_valid(beat_valid), .burst_done(burst_done), .req_err(req_err)
  );

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    wd = 0;
  string tag = "R1";
  int    beat_q[$];
  int    done_cyc = -1;
  int    err_cyc = -1;
  int    busy_end = -1;

  task automatic cmp(string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: got %b expected %b", tag, nm, cyc, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic eb;
    eb = (beat_q.size() > 0) && (beat_q[0] == cyc);
    if (eb) void'(beat_q.pop_front());
    cmp("req_ready",  req_ready,  cyc > busy_end);
    cmp("beat_valid", beat_valid, eb);
    cmp("burst_done", burst_done, cyc == done_cyc);
    cmp("req_err",    req_err,    cyc == err_cyc);
  endtask

  task automatic model_accept();
    int slow;
    int t;
    if (req_chan > 3'd5) begin
      err_cyc = cyc + 1;
    end else begin
      slow = slow_mode[req_chan] ? 1 : 0;
      t = cyc + 4 + slow;
      for (int i = 0; i <= int'(req_len); i++) begin
        beat_q.push_back(t);
        done_cyc = t;
        t += 2 + slow;
      end
      busy_end = done_cyc;
    end
  endtask

  task automatic tick();
    check_outputs();
    if (req_valid && cyc > busy_end) model_accept();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic drain();
    while (cyc <= busy_end) tick();
    tick();
  endtask

  task automatic send(input logic [2:0] ch, input logic [2:0] len);
    req_valid = 1'b1;
    req_chan  = ch;
    req_len   = len;
    tick();
    req_valid = 1'b0;
    drain();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_chan = '0;
    req_len = '0;
    slow_mode = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    tag = "R1";
    cmp("req_ready", req_ready, 1'b1);
    cmp("beat_valid", beat_valid, 1'b0);
    cmp("burst_done", burst_done, 1'b0);
    cmp("req_err", req_err, 1'b0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R3, R4, R8: normal 4-beat burst
    tag = "R3_R4";
    send(3'd0, 3'd3);
    // R8: single beat, normal and slow; 8 beats
    tag = "R8";
    send(3'd1, 3'd0);
    slow_mode = 6'b000010;
    send(3'd1, 3'd0);
    slow_mode = '0;
    send(3'd3, 3'd7);
    // R5: slow 8-beat burst
    tag = "R5";
    slow_mode = 6'b000100;
    send(3'd2, 3'd7);
    // R6: every other channel slow, selected one not
    tag = "R6";
    slow_mode = 6'b111101;
    send(3'd1, 3'd2);
    // R7: mode changes mid-burst
    tag = "R7";
    slow_mode = 6'b000100;
    req_valid = 1'b1; req_chan = 3'd2; req_len = 3'd3;
    tick();
    req_valid = 1'b0;
    repeat (3) tick();
    slow_mode = 6'b000000;
    drain();
    slow_mode = 6'b111111;
    req_valid = 1'b1; req_chan = 3'd4; req_len = 3'd2;
    tick();
    req_valid = 1'b0;
    tick();
    slow_mode = 6'b000000;
    drain();
    // R11: several slow channels at once
    tag = "R11";
    slow_mode = 6'b101010;
    send(3'd1, 3'd1);
    send(3'd3, 3'd1);
    send(3'd5, 3'd2);
    send(3'd0, 3'd1);
    // R2 and R9: request held valid across back-to-back bursts
    tag = "R2_R9";
    slow_mode = 6'b010000;
    req_valid = 1'b1; req_chan = 3'd4; req_len = 3'd1;
    repeat (25) tick();
    req_chan = 3'd0;
    repeat (20) tick();
    req_valid = 1'b0;
    drain();
    // R10: bad channels, then a good request straight after
    tag = "R10";
    slow_mode = '0;
    req_valid = 1'b1; req_chan = 3'd6; req_len = 3'd2;
    tick();
    req_chan = 3'd7;
    tick();
    req_chan = 3'd5; req_len = 3'd0;
    tick();
    req_valid = 1'b0;
    drain();
    repeat (4) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule